// File: doc/BRIEF.md
# Arcade Memory-Map Address Decoder

This block turns every bus access of an 8-bit processor with a 16-bit address into a single chip select. The top four address bits split the 64K space into sixteen 4K pages. Pages 0x0 to 0x8 are an overlay area. Writes there always land in RAM. Reads come from ROM or RAM, depending on a separate overlay control bit. Pages 0x9 to 0xB are plain RAM, and pages 0xD to 0xF are ROM.

Page 0xC holds the peripherals and is decoded in two tiers. Address bits 11..10 pick a group:

- colour-palette write strobe
- unused
- peripheral sub-page
- battery-backed NVRAM

Inside the peripheral sub-page, address bits 9..8 and a few low address bits choose one of these:

- one of two parallel-port chips
- the display-control latch
- the special-function chips
- the input buffer / watchdog-clear strobe

The decoder is purely combinational. Every output is gated by the valid-memory strobe, and at most one output is high at a time. The devices themselves, bus timing and the watchdog counter are outside the block.

Top module: `amap_decoder`

## Requirements
- R1: With vma high, an access of either direction to pages 0xD, 0xE or 0xF (addr[15:12]) raises only rom_cs.
- R2: With vma high, a write (rd_nwr=0) to pages 0x0 through 0x8 raises only ram_cs, whatever rom_overlay is.
- R3: With vma high, a read (rd_nwr=1) from pages 0x0 through 0x8 raises only rom_cs when rom_overlay=1 and only ram_cs when rom_overlay=0.
- R4: With vma high, any access to pages 0x9, 0xA or 0xB raises only ram_cs, whatever rom_overlay is.
- R5: In page 0xC with addr[11:10]=00, a write raises only color_we and a read raises no output, because the palette has no read path.
- R6: In page 0xC, addr[11:10]=11 raises only nvram_cs for either direction, and addr[11:10]=01 raises no output.
- R7: In page 0xC with addr[11:8]=1000, the result depends on addr[3] and addr[2]. With addr[3]=1 and addr[2]=1, only pia_a_cs is raised. With addr[3]=0 and addr[2]=1, only pia_b_cs is raised. With addr[2]=0, no output is raised.
- R8: In page 0xC, addr[11:8]=1001 raises only screen_cs and addr[11:8]=1010 raises only special_cs, for either direction.
- R9: In page 0xC with addr[11:8]=1011, the result depends on direction and addr[0]. A write raises only wdog_clr. A read with addr[0]=0 raises only inbuf_en. A read with addr[0]=1 raises no output.
- R10: With vma low, every output is low regardless of the other inputs.
- R11: For every combination of inputs, at most one of the ten outputs is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 16 | Bus address |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| vma | input | 1 | Valid-memory strobe; gates every select |
| rom_overlay | input | 1 | Read source for pages 0x0-0x8: 1 = ROM, 0 = RAM |
| ram_cs | output | 1 | RAM select |
| rom_cs | output | 1 | ROM select |
| color_we | output | 1 | Colour-palette write strobe |
| nvram_cs | output | 1 | Battery-backed RAM select |
| pia_a_cs | output | 1 | First parallel-port chip select |
| pia_b_cs | output | 1 | Second parallel-port chip select |
| screen_cs | output | 1 | Display-control latch select |
| special_cs | output | 1 | Special-function chip select |
| inbuf_en | output | 1 | Input buffer enable |
| wdog_clr | output | 1 | Watchdog-clear strobe |

## Verification
The input buffer and the watchdog-clear strobe share page 0xCB. The two parallel-port chips share the same sub-page and differ only in addr[3]. A careless decode could therefore fire two of these outputs for one access. The bench reads and writes 0xCB00 and 0xCB01, and walks addr[3:2] at 0xC800, in both directions. For each access it checks that the right single output is high and that its neighbour stays low. A full sweep over every address, direction and overlay value then compares all ten outputs against an independent model and checks that at most one output is high.

// File: rtl/amap_pkg.sv
package amap_pkg;

  typedef enum logic [1:0] {
    RG_OVERLAY = 2'd0,
    RG_RAM     = 2'd1,
    RG_IO      = 2'd2,
    RG_ROM     = 2'd3
  } region_t;

  typedef enum logic [3:0] {
    IO_NONE    = 4'd0,
    IO_COLOR   = 4'd1,
    IO_NVRAM   = 4'd2,
    IO_PIA_A   = 4'd3,
    IO_PIA_B   = 4'd4,
    IO_SCREEN  = 4'd5,
    IO_SPECIAL = 4'd6,
    IO_INBUF   = 4'd7,
    IO_WDOG    = 4'd8
  } io_dev_t;

  // first-tier group codes carried on addr[11:10]
  localparam logic [1:0] GRP_COLOR = 2'b00;
  localparam logic [1:0] GRP_IDLE  = 2'b01;
  localparam logic [1:0] GRP_PERIPH = 2'b10;
  localparam logic [1:0] GRP_NVRAM = 2'b11;

  // second-tier codes on addr[9:8] inside the peripheral group
  localparam logic [1:0] SUB_PIA     = 2'b00;
  localparam logic [1:0] SUB_SCREEN  = 2'b01;
  localparam logic [1:0] SUB_SPECIAL = 2'b10;
  localparam logic [1:0] SUB_BUFWD   = 2'b11;

  localparam int NUM_SEL = 10;

endpackage

// File: rtl/amap_region_dec.sv
module amap_region_dec
  import amap_pkg::*;
#(
  parameter int              PAGE_W      = 4,
  parameter logic [PAGE_W-1:0] OVERLAY_LAST = 'h8,
  parameter logic [PAGE_W-1:0] IO_PAGE      = 'hC,
  parameter logic [PAGE_W-1:0] ROM_FIRST    = 'hD
) (
  input  logic [PAGE_W-1:0] page,
  output region_t           region
);

  always_comb begin
    if (page >= ROM_FIRST)          region = RG_ROM;
    else if (page == IO_PAGE)       region = RG_IO;
    else if (page > OVERLAY_LAST)   region = RG_RAM;
    else                            region = RG_OVERLAY;
  end

  // R1: the top pages never fall into the overlay area
  always_comb begin
    if (!$isunknown(page) && page >= ROM_FIRST)
      a_r1_rom_pages: assert (region != RG_OVERLAY);
  end

endmodule

// File: rtl/amap_io_dec.sv
module amap_io_dec
  import amap_pkg::*;
(
  input  logic [1:0] grp,
  input  logic [1:0] sub,
  input  logic       a3,
  input  logic       a2,
  input  logic       a0,
  input  logic       rd,
  output io_dev_t    dev
);

  io_dev_t periph_dev;

  // second tier: peripheral sub-page
  always_comb begin
    periph_dev = IO_NONE;
    unique case (sub)
      SUB_PIA: begin
        if (a2 && a3)       periph_dev = IO_PIA_A;
        else if (a2)        periph_dev = IO_PIA_B;
      end
      SUB_SCREEN:  periph_dev = IO_SCREEN;
      SUB_SPECIAL: periph_dev = IO_SPECIAL;
      SUB_BUFWD: begin
        if (!rd)            periph_dev = IO_WDOG;
        else if (!a0)       periph_dev = IO_INBUF;
      end
      default:     periph_dev = IO_NONE;
    endcase
  end

  // first tier: group select
  always_comb begin
    dev = IO_NONE;
    unique case (grp)
      GRP_COLOR:  dev = rd ? IO_NONE : IO_COLOR;
      GRP_IDLE:   dev = IO_NONE;
      GRP_PERIPH: dev = periph_dev;
      GRP_NVRAM:  dev = IO_NVRAM;
      default:    dev = IO_NONE;
    endcase
  end

  // R5: palette strobe is a write-only path
  always_comb begin
    if (!$isunknown(rd) && dev == IO_COLOR)
      a_r5_color_write_only: assert (!rd);
  end

  // R9: buffer only on reads with addr[0] low, watchdog only on writes
  always_comb begin
    if (!$isunknown({rd, a0}) && dev == IO_INBUF)
      a_r9_inbuf_read_even: assert (rd && !a0);
    if (!$isunknown(rd) && dev == IO_WDOG)
      a_r9_wdog_on_write: assert (!rd);
  end

  // R7: parallel-port chips need addr[2] high
  always_comb begin
    if (!$isunknown(a2) && (dev == IO_PIA_A || dev == IO_PIA_B))
      a_r7_pia_needs_a2: assert (a2);
  end

endmodule

// File: rtl/amap_sel_drive.sv
module amap_sel_drive
  import amap_pkg::*;
(
  input  region_t region,
  input  io_dev_t io_dev,
  input  logic    rd,
  input  logic    vma,
  input  logic    overlay,
  output logic [NUM_SEL-1:0] sel
);

  // sel bit order: 9 ram, 8 rom, 7 color, 6 nvram, 5 pia_a, 4 pia_b,
  // 3 screen, 2 special, 1 inbuf, 0 wdog
  localparam int B_RAM = 9, B_ROM = 8, B_COLOR = 7, B_NVRAM = 6, B_PIA_A = 5;
  localparam int B_PIA_B = 4, B_SCREEN = 3, B_SPECIAL = 2, B_INBUF = 1, B_WDOG = 0;

  logic [NUM_SEL-1:0] raw;

  always_comb begin
    raw = '0;
    unique case (region)
      RG_OVERLAY: begin
        if (rd && overlay) raw[B_ROM] = 1'b1;
        else               raw[B_RAM] = 1'b1;
      end
      RG_RAM: raw[B_RAM] = 1'b1;
      RG_ROM: raw[B_ROM] = 1'b1;
      RG_IO: begin
        unique case (io_dev)
          IO_COLOR:   raw[B_COLOR]   = 1'b1;
          IO_NVRAM:   raw[B_NVRAM]   = 1'b1;
          IO_PIA_A:   raw[B_PIA_A]   = 1'b1;
          IO_PIA_B:   raw[B_PIA_B]   = 1'b1;
          IO_SCREEN:  raw[B_SCREEN]  = 1'b1;
          IO_SPECIAL: raw[B_SPECIAL] = 1'b1;
          IO_INBUF:   raw[B_INBUF]   = 1'b1;
          IO_WDOG:    raw[B_WDOG]    = 1'b1;
          default:    raw = '0;
        endcase
      end
      default: raw = '0;
    endcase
  end

  assign sel = vma ? raw : '0;

  // R11: at most one select at a time
  always_comb begin
    if (!$isunknown(sel))
      a_r11_onehot_sel: assert ($onehot0(sel));
  end

  // R10: nothing selected without a valid cycle
  always_comb begin
    if (!$isunknown(vma) && !vma)
      a_r10_idle_no_vma: assert (sel == '0);
  end

  // R2: overlay writes never reach ROM
  always_comb begin
    if (!$isunknown({vma, rd}) && vma && !rd && region == RG_OVERLAY)
      a_r2_overlay_write_ram: assert (sel[B_RAM] && !sel[B_ROM]);
  end

endmodule

// File: rtl/amap_decoder.sv
module amap_decoder
  import amap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_nwr,
  input  logic              vma,
  input  logic              rom_overlay,
  output logic              ram_cs,
  output logic              rom_cs,
  output logic              color_we,
  output logic              nvram_cs,
  output logic              pia_a_cs,
  output logic              pia_b_cs,
  output logic              screen_cs,
  output logic              special_cs,
  output logic              inbuf_en,
  output logic              wdog_clr
);

  localparam int PAGE_LSB = ADDR_W - PAGE_W;
  localparam int GRP_LSB  = PAGE_LSB - 2;
  localparam int SUB_LSB  = PAGE_LSB - 4;

  region_t            region;
  io_dev_t            io_dev;
  logic [NUM_SEL-1:0] sel;
  logic               unused_addr_bits;

  assign unused_addr_bits = ^{addr[SUB_LSB-1:4], addr[1]};

  amap_region_dec #(
    .PAGE_W(PAGE_W)
  ) u_region (
    .page  (addr[ADDR_W-1:PAGE_LSB]),
    .region(region)
  );

  amap_io_dec u_io (
    .grp(addr[GRP_LSB +: 2]),
    .sub(addr[SUB_LSB +: 2]),
    .a3 (addr[3]),
    .a2 (addr[2]),
    .a0 (addr[0]),
    .rd (rd_nwr),
    .dev(io_dev)
  );

  amap_sel_drive u_drive (
    .region (region),
    .io_dev (io_dev),
    .rd     (rd_nwr),
    .vma    (vma),
    .overlay(rom_overlay),
    .sel    (sel)
  );

  assign {ram_cs, rom_cs, color_we, nvram_cs, pia_a_cs, pia_b_cs,
          screen_cs, special_cs, inbuf_en, wdog_clr} = sel;

endmodule

// File: tb/amap_decoder_test.sv
module amap_decoder_test;

  logic        clk;
  logic        rst_n;
  logic [15:0] addr;
  logic        rd_nwr, vma, rom_overlay;
  logic ram_cs, rom_cs, color_we, nvram_cs, pia_a_cs, pia_b_cs;
  logic screen_cs, special_cs, inbuf_en, wdog_clr;

  int checks = 0;
  int failures = 0;

  amap_decoder uut (
    .addr(addr), .rd_nwr(rd_nwr), .vma(vma), .rom_overlay(rom_overlay),
    .ram_cs(ram_cs), .rom_cs(rom_cs), .color_we(color_we), .nvram_cs(nvram_cs),
    .pia_a_cs(pia_a_cs), .pia_b_cs(pia_b_cs), .screen_cs(screen_cs),
    .special_cs(special_cs), .inbuf_en(inbuf_en), .wdog_clr(wdog_clr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected outputs: {ram,rom,color,nvram,pia_a,pia_b,screen,special,inbuf,wdog}
  function automatic logic [9:0] model(input logic [15:0] a, input logic rd,
                                       input logic v, input logic ov);
    logic [9:0] e = '0;
    if (!v) return e;                                   // R10
    if (a[15:12] >= 4'hD) e[8] = 1'b1;                  // R1
    else if (a[15:12] <= 4'h8) begin
      if (rd && ov) e[8] = 1'b1; else e[9] = 1'b1;      // R2 R3
    end
    else if (a[15:12] != 4'hC) e[9] = 1'b1;             // R4
    else begin
      case (a[11:8])
        4'h0, 4'h1, 4'h2, 4'h3: e[7] = !rd;             // R5
        4'hC, 4'hD, 4'hE, 4'hF: e[6] = 1'b1;            // R6
        4'h8: begin                                      // R7
          e[5] = a[3] & a[2];
          e[4] = !a[3] & a[2];
        end
        4'h9: e[3] = 1'b1;                              // R8
        4'hA: e[2] = 1'b1;
        4'hB: begin                                      // R9
          e[0] = !rd;
          e[1] = rd & !a[0];
        end
        default: e = '0;
      endcase
    end
    return e;
  endfunction

  function automatic logic [9:0] actual();
    return {ram_cs, rom_cs, color_we, nvram_cs, pia_a_cs, pia_b_cs,
            screen_cs, special_cs, inbuf_en, wdog_clr};
  endfunction

  task automatic check(input string req, input logic [9:0] exp);
    logic [9:0] act = actual();
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s addr=%h rd=%b vma=%b ov=%b actual=%b expected=%b",
               req, addr, rd_nwr, vma, rom_overlay, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic rd, input logic v,
                        input logic ov, input string req, input logic [9:0] exp);
    @(negedge clk);
    addr = a; rd_nwr = rd; vma = v; rom_overlay = ov;
    #2;
    check(req, exp);
  endtask

  task automatic t_reset_idle();
    access(16'h0000, 1'b1, 1'b0, 1'b0, "R10", 10'b0);
    access(16'hCB00, 1'b0, 1'b0, 1'b1, "R10", 10'b0);
    access(16'hF000, 1'b1, 1'b0, 1'b1, "R10", 10'b0);
  endtask

  task automatic t_rom_pages();
    access(16'hD123, 1'b1, 1'b1, 1'b0, "R1", 10'b0100000000);
    access(16'hFFFF, 1'b0, 1'b1, 1'b0, "R1", 10'b0100000000);
  endtask

  task automatic t_overlay();
    access(16'h0000, 1'b0, 1'b1, 1'b1, "R2", 10'b1000000000);
    access(16'h8FFF, 1'b0, 1'b1, 1'b0, "R2", 10'b1000000000);
    access(16'h4000, 1'b1, 1'b1, 1'b1, "R3", 10'b0100000000);
    access(16'h8FFF, 1'b1, 1'b1, 1'b0, "R3", 10'b1000000000);
  endtask

  task automatic t_plain_ram();
    access(16'h9000, 1'b1, 1'b1, 1'b1, "R4", 10'b1000000000);
    access(16'hBFFF, 1'b0, 1'b1, 1'b1, "R4", 10'b1000000000);
  endtask

  task automatic t_io_groups();
    access(16'hC00F, 1'b0, 1'b1, 1'b0, "R5", 10'b0010000000);
    access(16'hC30F, 1'b1, 1'b1, 1'b0, "R5", 10'b0000000000);
    access(16'hCC10, 1'b1, 1'b1, 1'b0, "R6", 10'b0001000000);
    access(16'hCFFF, 1'b0, 1'b1, 1'b0, "R6", 10'b0001000000);
    access(16'hC400, 1'b0, 1'b1, 1'b0, "R6", 10'b0000000000);
  endtask

  task automatic t_pia_pair();
    access(16'hC80C, 1'b1, 1'b1, 1'b0, "R7", 10'b0000100000);
    access(16'hC804, 1'b0, 1'b1, 1'b0, "R7", 10'b0000010000);
    access(16'hC808, 1'b1, 1'b1, 1'b0, "R7", 10'b0000000000);
    access(16'hC800, 1'b0, 1'b1, 1'b0, "R7", 10'b0000000000);
    access(16'hC900, 1'b1, 1'b1, 1'b0, "R8", 10'b0000001000);
    access(16'hCAFF, 1'b0, 1'b1, 1'b0, "R8", 10'b0000000100);
  endtask

  task automatic t_buf_wdog();
    access(16'hCB00, 1'b1, 1'b1, 1'b0, "R9", 10'b0000000010);
    access(16'hCB00, 1'b0, 1'b1, 1'b0, "R9", 10'b0000000001);
    access(16'hCB01, 1'b1, 1'b1, 1'b0, "R9", 10'b0000000000);
    access(16'hCB01, 1'b0, 1'b1, 1'b0, "R9", 10'b0000000001);
  endtask

  task automatic t_sweep();
    for (int ov = 0; ov < 2; ov++) begin
      for (int rd = 0; rd < 2; rd++) begin
        for (int a = 0; a < 65536; a++) begin
          addr = 16'(a); rd_nwr = rd[0]; vma = 1'b1; rom_overlay = ov[0];
          #1;
          check("R11", model(addr, rd_nwr, vma, rom_overlay));
          if (!$onehot0(actual())) begin
            checks++; failures++;
            $display("FAIL R11 addr=%h actual=%b expected=onehot0", addr, actual());
          end
        end
      end
    end
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    addr = '0; rd_nwr = 1'b1; vma = 1'b0; rom_overlay = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset_idle();
    t_rom_pages();
    t_overlay();
    t_plain_ram();
    t_io_groups();
    t_pia_pair();
    t_buf_wdog();
    t_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule